// File: doc/BRIEF.md
# Per-Region Bus Ready Stall Time-out Monitor

This block sits beside an external memory port and watches for accesses held up by the port's ready input staying low. For each access it counts the consecutive cycles in which ready is sampled low. It compares that count against a programmable limit taken from one of four address regions. When the count reaches the limit, it sends a one-cycle time-out pulse to the DMA controller, which can then disable the affected channel.

An access begins on a cycle in which `acc_valid` is high and no access is already in progress. It stays in progress while `acc_valid` is high and `bus_ready` is low. It ends on the first cycle in which `bus_ready` is high or `acc_valid` is low.

The region for an access is the value of `acc_region` in the first cycle of that access. Each region has an 8-bit limit. The limits are written and read back through a small register port, where `cfg_addr` value n selects the limit of region n. A limit of zero turns detection off for that region.

Top module: `bus_stall_timeout`

## Requirements
- R1: After reset, every region limit reads back as 255 on `cfg_rdata`. Readback is combinational from `cfg_addr`.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored as the limit of region `cfg_addr`. From the next cycle on, that value reads back when `cfg_addr` selects the region.
- R3: `tmo_pulse` is high during the cycle that follows the L-th consecutive clock edge at which `acc_valid` is high and `bus_ready` is low. L is the nonzero limit of the access's region, and can be any value from 1 to 255.
- R4: An access whose region value is n is timed against the limit written with `cfg_addr` equal to n, for every n from 0 to 3.
- R5: A clock edge at which `bus_ready` is sampled high ends the access and clears the stall count. A following stall needs a full L new low samples before it times out.
- R6: A clock edge at which `acc_valid` is low withdraws the access and clears the stall count. A following stall needs a full L new low samples before it times out.
- R7: `tmo_pulse` lasts exactly one cycle. It is raised at most once per access, however long the stall goes on after the time-out.
- R8: A region whose limit is 0 never raises `tmo_pulse`, however long its stall lasts.
- R9: The region is taken from `acc_region` in the first cycle of an access. Changes to `acc_region` while that access continues have no effect on which limit applies.
- R10: `tmo_pulse` is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is being presented on the memory port |
| acc_region | input | 2 | Region targeted by the access; sampled in its first cycle |
| bus_ready | input | 1 | External ready; low means the access is stalled |
| cfg_we | input | 1 | Write strobe for the limit registers |
| cfg_addr | input | 2 | Limit register select, equal to the region number |
| cfg_wdata | input | 8 | Limit value to write |
| cfg_rdata | output | 8 | Limit value of the selected region |
| tmo_pulse | output | 1 | One-cycle time-out indication to the DMA controller |

## Verification
The time-out pulse comes from one register. It is due in the cycle right after the clock edge that takes the L-th low ready sample, so the bench drives inputs at the falling edge and checks `tmo_pulse` 1 ns after every rising edge. A model in the bench counts stall samples the same way and predicts the pulse for that exact cycle, so an early, late, repeated or missing pulse is reported. Limit readback is combinational: it is checked 1 ns after `cfg_addr` changes, and a written value is checked after the writing edge.

// File: rtl/stall_tmo_pkg.sv
package stall_tmo_pkg;

   // Default geometry of the monitor.
   localparam int unsigned DEF_REGIONS = 4;
   localparam int unsigned DEF_LIMIT_W = 8;

   // Readback implementation choices.
   typedef enum logic [0:0] {
      RDBK_COMB = 1'b0,
      RDBK_FLOP = 1'b1
   } rdbk_mode_e;

endpackage

// File: rtl/stall_tmo_limits.sv
module stall_tmo_limits
   import stall_tmo_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = DEF_REGIONS,
   parameter int unsigned LIMIT_W     = DEF_LIMIT_W,
   parameter rdbk_mode_e  RDBK_MODE   = RDBK_COMB,
   localparam int unsigned REGION_W   = $clog2(NUM_REGIONS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [REGION_W-1:0] cfg_addr,
   input  logic [LIMIT_W-1:0]  cfg_wdata,
   output logic [LIMIT_W-1:0]  cfg_rdata,
   output logic [LIMIT_W-1:0]  lim [NUM_REGIONS]
);

   // One limit register per region; the reset value is the largest limit.
   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lim
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lim[g] <= '1;
         end else if (cfg_we && (cfg_addr == REGION_W'(g))) begin
            lim[g] <= cfg_wdata;
         end
      end
   end

   // Readback: combinational select, or registered select.
   if (RDBK_MODE == RDBK_COMB) begin : g_rd_comb
      always_comb cfg_rdata = lim[cfg_addr];
   end else begin : g_rd_flop
      logic [LIMIT_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rd_q <= '1;
         else        rd_q <= lim[cfg_addr];
      end
      always_comb cfg_rdata = rd_q;
   end

   // R2: a write lands in the addressed register.
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> (lim[$past(cfg_addr)] == $past(cfg_wdata)));

endmodule

// File: rtl/stall_tmo_tracker.sv
module stall_tmo_tracker #(
   parameter int unsigned NUM_REGIONS = 4,
   localparam int unsigned REGION_W   = $clog2(NUM_REGIONS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic [REGION_W-1:0] acc_region,
   input  logic                bus_ready,
   output logic                stall,
   output logic [REGION_W-1:0] region_sel
);

   logic                in_acc_q;
   logic [REGION_W-1:0] region_q;
   logic                first_cyc;

   // An access continues across an edge only while it is stalled.
   always_comb stall     = acc_valid && !bus_ready;
   always_comb first_cyc = acc_valid && !in_acc_q;
   always_comb region_sel = first_cyc ? acc_region : region_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_acc_q <= 1'b0;
         region_q <= '0;
      end else begin
         in_acc_q <= stall;
         if (acc_valid) region_q <= region_sel;
      end
   end

   // R9: the region in use does not change while an access continues.
   a_r9_region_hold: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (!acc_valid || (region_sel == $past(region_sel))));

endmodule

// File: rtl/stall_tmo_counter.sv
module stall_tmo_counter #(
   parameter int unsigned LIMIT_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               stall,
   input  logic [LIMIT_W-1:0] limit,
   output logic               tmo
);

   logic [LIMIT_W-1:0] cnt_q;
   logic               fired_q;
   logic               tmo_q;
   logic [LIMIT_W:0]   cnt_inc;
   logic               hit;

   always_comb cnt_inc = {1'b0, cnt_q} + 1'b1;
   always_comb hit = stall && !fired_q && (limit != '0)
                     && (cnt_inc == {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         fired_q <= 1'b0;
         tmo_q   <= 1'b0;
      end else begin
         tmo_q <= hit;
         if (!stall) begin
            cnt_q   <= '0;
            fired_q <= 1'b0;
         end else begin
            fired_q <= fired_q || hit;
            if (!fired_q && (cnt_q != '1)) cnt_q <= cnt_inc[LIMIT_W-1:0];
         end
      end
   end

   always_comb tmo = tmo_q;

   // R5 / R6: any edge without a stall leaves the count at zero.
   a_r5_count_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !stall |=> (cnt_q == '0));
   // R7: the pulse is one cycle wide.
   a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q |=> !tmo_q);
   // R3: a pulse is always caused by a stalled sample.
   a_r3_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_q |-> $past(stall));

endmodule

// File: rtl/bus_stall_timeout.sv
module bus_stall_timeout
   import stall_tmo_pkg::*;
#(
   parameter int unsigned NUM_REGIONS = DEF_REGIONS,
   parameter int unsigned LIMIT_W     = DEF_LIMIT_W,
   parameter rdbk_mode_e  RDBK_MODE   = RDBK_COMB,
   localparam int unsigned REGION_W   = $clog2(NUM_REGIONS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic [REGION_W-1:0] acc_region,
   input  logic                bus_ready,
   input  logic                cfg_we,
   input  logic [REGION_W-1:0] cfg_addr,
   input  logic [LIMIT_W-1:0]  cfg_wdata,
   output logic [LIMIT_W-1:0]  cfg_rdata,
   output logic                tmo_pulse
);

   // Elaboration-time checks on the parameters.
   if (NUM_REGIONS < 2 || NUM_REGIONS != (1 << REGION_W)) begin : g_chk_regions
      $error("NUM_REGIONS must be a power of two, at least 2");
   end
   if (LIMIT_W < 1 || LIMIT_W > 16) begin : g_chk_limit
      $error("LIMIT_W must lie in 1..16");
   end

   logic [LIMIT_W-1:0]  lim [NUM_REGIONS];
   logic [LIMIT_W-1:0]  sel_limit;
   logic [REGION_W-1:0] region_sel;
   logic                stall;

   stall_tmo_limits #(
      .NUM_REGIONS (NUM_REGIONS),
      .LIMIT_W     (LIMIT_W),
      .RDBK_MODE   (RDBK_MODE)
   ) u_limits (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_addr  (cfg_addr),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .lim       (lim)
   );

   stall_tmo_tracker #(
      .NUM_REGIONS (NUM_REGIONS)
   ) u_tracker (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_region (acc_region),
      .bus_ready  (bus_ready),
      .stall      (stall),
      .region_sel (region_sel)
   );

   always_comb sel_limit = lim[region_sel];

   stall_tmo_counter #(
      .LIMIT_W (LIMIT_W)
   ) u_counter (
      .clk   (clk),
      .rst_n (rst_n),
      .stall (stall),
      .limit (sel_limit),
      .tmo   (tmo_pulse)
   );

   // R8: no pulse follows a sample taken against a zero limit.
   a_r8_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |-> ($past(sel_limit) != '0));
   // R3: the pulse follows a stalled cycle seen at the ports.
   a_r3_port_cause: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |-> $past(acc_valid && !bus_ready));

endmodule

// File: tb/bus_stall_timeout_bench.sv
`timescale 1ns/1ps
module bus_stall_timeout_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       acc_valid = 1'b0;
   logic [1:0] acc_region = '0;
   logic       bus_ready = 1'b1;
   logic       cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       tmo_pulse;

   int vec_cnt = 0;
   int bad_cnt = 0;

   // Model state.
   int m_lim [4];
   int m_k = 0;
   bit m_fired = 0;
   bit m_inacc = 0;
   int m_reg = 0;

   always #2.5 clk = ~clk;

   bus_stall_timeout u_bus_stall_timeout (
      .clk        (clk),
      .rst_n      (rst_n),
      .acc_valid  (acc_valid),
      .acc_region (acc_region),
      .bus_ready  (bus_ready),
      .cfg_we     (cfg_we),
      .cfg_addr   (cfg_addr),
      .cfg_wdata  (cfg_wdata),
      .cfg_rdata  (cfg_rdata),
      .tmo_pulse  (tmo_pulse)
   );

   task automatic check(input string req, input int act, input int exp_v);
      vec_cnt++;
      if (act != exp_v) begin
         bad_cnt++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp_v, $time);
      end
   endtask

   task automatic readback(input int r, input string req);
      @(negedge clk);
      cfg_addr = 2'(r);
      #1;
      check(req, int'(cfg_rdata), m_lim[r]);
   endtask

   task automatic wr_limit(input int r, input int val);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_addr = 2'(r);
      cfg_wdata = 8'(val);
      @(posedge clk);
      #1;
      cfg_we = 1'b0;
      m_lim[r] = val;
   endtask

   // One bus cycle: drive at the falling edge, predict, check after the rise.
   task automatic step(input bit v, input int r, input bit rdy, input string req);
      bit hit;
      @(negedge clk);
      acc_valid = v;
      acc_region = 2'(r);
      bus_ready = rdy;
      hit = 0;
      if (v && !m_inacc) m_reg = r;
      if (v && !rdy) begin
         if (!m_fired) begin
            m_k++;
            if (m_lim[m_reg] != 0 && m_k == m_lim[m_reg]) begin
               hit = 1;
               m_fired = 1;
            end
         end
         m_inacc = 1;
      end else begin
         m_k = 0;
         m_fired = 0;
         m_inacc = 0;
      end
      @(posedge clk);
      #1;
      check(req, int'(tmo_pulse), int'(hit));
   endtask

   task automatic stall_run(input int r, input int n, input string req);
      for (int i = 0; i < n; i++) step(1'b1, r, 1'b0, req);
   endtask

   initial begin
      #(200000 * 5);
      bad_cnt++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) m_lim[i] = 255;
      repeat (3) @(posedge clk);
      #1;
      check("R10", int'(tmo_pulse), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R10", int'(tmo_pulse), 0);
      // R1: reset values of all limits.
      for (int r = 0; r < 4; r++) readback(r, "R1");

      // R2 / R4: distinct values per region, read back.
      for (int r = 0; r < 4; r++) wr_limit(r, 17 * r + 5);
      for (int r = 0; r < 4; r++) readback(r, "R2");

      // R3 / R4 / R8 / R7: sweep of limits 0..12 on every region.
      for (int r = 0; r < 4; r++) begin
         for (int l = 0; l <= 12; l++) begin
            wr_limit(r, l);
            readback(r, "R4");
            stall_run(r, (l == 0) ? 20 : l + 4, (l == 0) ? "R8" : "R3");
            step(1'b1, r, 1'b1, "R7");
            step(1'b0, r, 1'b1, "R7");
         end
      end

      // R3 boundary: the largest limit.
      wr_limit(2, 255);
      stall_run(2, 258, "R3");
      step(1'b0, 0, 1'b1, "R3");

      // R5: ready high mid-stall restarts the count.
      wr_limit(1, 4);
      stall_run(1, 3, "R5");
      step(1'b1, 1, 1'b1, "R5");
      stall_run(1, 6, "R5");
      step(1'b0, 0, 1'b1, "R5");

      // R6: withdrawing the access restarts the count.
      stall_run(1, 3, "R6");
      step(1'b0, 1, 1'b0, "R6");
      stall_run(1, 6, "R6");
      step(1'b0, 0, 1'b1, "R6");

      // R7: back-to-back one-cycle accesses with limit 1.
      wr_limit(3, 1);
      for (int i = 0; i < 5; i++) begin
         step(1'b1, 3, 1'b0, "R7");
         step(1'b1, 3, 1'b1, "R7");
      end
      step(1'b0, 0, 1'b1, "R7");

      // R9: the region changes mid-access; the first region's limit applies.
      wr_limit(0, 3);
      wr_limit(1, 10);
      step(1'b1, 0, 1'b0, "R9");
      stall_run(1, 12, "R9");
      step(1'b0, 0, 1'b1, "R9");
      step(1'b1, 1, 1'b0, "R9");
      stall_run(0, 12, "R9");
      step(1'b0, 0, 1'b1, "R9");

      // R8: a zero limit stays silent on a long stall.
      wr_limit(0, 0);
      stall_run(0, 300, "R8");
      step(1'b0, 0, 1'b1, "R8");

      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
      $finish;
   end

endmodule